// File: doc/BRIEF.md
# Clause-22 Management Interface Master

This block runs PHY management transactions over a two-wire management bus: a clock (MDC) and a bidirectional data line (MDIO). A host talks to it through a small byte port with eight addresses. Addresses 0 to 3 hold a 32-bit command word and addresses 4 to 7 hold a 32-bit status word. Within each word the lowest address holds the least significant byte. The host fills in the command fields and then sets the go bit, bit 31 of the command word, by writing address 3.

While a transaction is running, the block divides the system clock down to MDC and shifts out a 64-bit management frame, most significant bit first. On a read it releases the data line and shifts in the PHY's reply. When the frame ends, the block clears the go bit, and that is the only completion signal the host gets. After a read, the status word holds the result and a flag that marks a PHY that never answered. The data line is brought out as three signals: an output value, an output enable and a sampled input. A pad outside the block joins them into one tri-state line.

Top module: `mdio_master`

## Requirements
- R1: Byte address 0, 1, 2 or 3 reaches command bits 7:0, 15:8, 23:16 or 31:24. A write to one of these addresses stores the byte, and a read returns it.
- R2: When address 3 is written with bit 7 set, the go bit (command bit 31) is set. One system clock later a frame starts. The go bit clears by itself in the clock edge that ends the frame, which lasts 128*DIV_HALF system clocks.
- R3: Command bit 26 selects the transaction type: 1 is a write to the PHY, 0 is a read. The frame carries opcode 01 for a write and 10 for a read.
- R4: The frame is sent MSB first in this order: 32 ones, start bits 01, the opcode, the PHY address from command bits 25:21, the register number from command bits 20:16, then the turnaround. On a write the turnaround is 10 and it is followed by command bits 15:0.
- R5: MDC is low while the block is idle. During a frame, MDC is low for DIV_HALF system clocks and then high for DIV_HALF, giving 64 rising edges per frame. MDIO and its enable change only in the clock where MDC falls.
- R6: On a read, the output enable drops from frame bit 46 onward, which covers both turnaround bits and the 16 data bits. The input is sampled on each rising MDC edge, and the 16 data bits are taken MSB first.
- R7: At the end of a read, status bits 15:0 hold the 16 data bits and bits 30:16 are zero. Bit 31 is 1 if the second turnaround bit was sampled high (the PHY did not answer) and 0 otherwise. With no PHY on the line, the status word reads 0x8000FFFF.
- R8: While the go bit is set, writes to addresses 0 to 3 have no effect, so the command word cannot change during a frame.
- R9: After reset the command and status words are zero, MDC is low, and the output enable is low.
- R10: The status word changes only at the end of a read. A write transaction leaves it unchanged, and host writes to addresses 4 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Byte address: 0-3 command word, 4-7 status word |
| reg_we_i | input | 1 | Byte write strobe |
| reg_wdata_i | input | 8 | Byte write data |
| reg_rdata_o | output | 8 | Byte read data, combinational from the address |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable; low releases the line |
| mdio_i | input | 1 | Sampled data line |

## Verification
The assertions check four things on every cycle. MDIO and its enable hold still while MDC is high. The line is released and MDC is low whenever the go bit is clear. The go bit falls only together with the end of a frame. The command word does not change while the go bit stays set, and the status word changes only when a read completes. What the line actually carries can only be shown by the bench's scenarios, because a model PHY has to take part: the bit order and field placement of read and write frames, the turnaround answer, the captured read data and the failed-read flag with all ones. The bench's cycle model also compares MDC phase, frame length and register read-back against the design on every clock.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int REL_IDX    = 46;  // first bit the master releases on a read
  localparam int TA2_IDX    = 47;  // second turnaround bit, PHY must drive low
  localparam int DAT_IDX    = 48;  // first read data bit
  localparam int GO_BIT     = 31;
  localparam int DIR_BIT    = 26;
  localparam logic [1:0] SOF   = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] TA_WR = 2'b10;

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DIR_BIT:0] c);
    logic wr;
    wr = c[DIR_BIT];
    build_frame = {32'hFFFF_FFFF, SOF, (wr ? OP_WR : OP_RD), c[25:21], c[20:16],
                   (wr ? TA_WR : 2'b00), (wr ? c[15:0] : 16'h0000)};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             last;

  assign last   = run_i && (cnt_q == DIV_W'(DIV_HALF - 1));
  assign rise_o = last && !mdc_q;
  assign fall_o = last && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (last) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIR_BIT:0] cmd_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             mdio_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  output logic             ta_bad_o,
  output logic [15:0]      rdata_o
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q, wr_q, ta_bad_q;
  logic [15:0]           rd_q;
  logic                  last_bit;

  assign last_bit  = (idx_q == IDX_W'(FRAME_BITS - 1));
  assign done_o    = busy_q && fall_i && last_bit;
  assign busy_o    = busy_q;
  assign mdio_oe_o = busy_q && (wr_q || (idx_q < IDX_W'(REL_IDX)));
  assign mdio_o    = mdio_oe_o && sh_q[FRAME_BITS-1];
  assign ta_bad_o  = ta_bad_q;
  assign rdata_o   = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      sh_q     <= '0;
      idx_q    <= '0;
      wr_q     <= 1'b0;
      ta_bad_q <= 1'b0;
      rd_q     <= '0;
    end else begin
      if (start_i) begin
        busy_q   <= 1'b1;
        sh_q     <= build_frame(cmd_i);
        idx_q    <= '0;
        wr_q     <= cmd_i[DIR_BIT];
        ta_bad_q <= 1'b0;
      end else if (busy_q && fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
          idx_q <= idx_q + 1'b1;
        end
      end
      // sample on rising MDC, read frames only
      if (busy_q && rise_i && !wr_q) begin
        if (idx_q == IDX_W'(TA2_IDX)) ta_bad_q <= mdio_i;
        else if (idx_q >= IDX_W'(DAT_IDX)) rd_q <= {rd_q[14:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  addr_i,
  input  logic        we_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        done_i,
  input  logic        rd_fail_i,
  input  logic [15:0] rd_data_i,
  output logic [31:0] cmd_o,
  output logic [31:0] stat_o
);
  logic [31:0] cmd_q, stat_q;
  logic [31:0] sel_word;

  assign cmd_o    = cmd_q;
  assign stat_o   = stat_q;
  assign sel_word = addr_i[2] ? stat_q : cmd_q;
  assign rdata_o  = sel_word[{addr_i[1:0], 3'b000} +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      stat_q <= '0;
    end else if (done_i) begin
      cmd_q[GO_BIT] <= 1'b0;
      if (!cmd_q[DIR_BIT]) stat_q <= {rd_fail_i, 15'd0, rd_data_i};
    end else if (we_i && !addr_i[2] && !cmd_q[GO_BIT]) begin
      cmd_q[{addr_i[1:0], 3'b000} +: 8] <= wdata_i;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] reg_addr_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       mdc_o,
  output logic       mdio_o,
  output logic       mdio_oe_o,
  input  logic       mdio_i
);
  logic [31:0] cmd_q, stat_q;
  logic        busy, start, done, rise, fall, ta_bad;
  logic [15:0] rd_data;

  assign start = cmd_q[GO_BIT] && !busy;

  mdio_regs i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .done_i    (done),
    .rd_fail_i (ta_bad),
    .rd_data_i (rd_data),
    .cmd_o     (cmd_q),
    .stat_o    (stat_q)
  );

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) i_clkdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cmd_i     (cmd_q[DIR_BIT:0]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .ta_bad_o  (ta_bad),
    .rdata_o   (rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mdc_i,
  input logic        mdio_i,
  input logic        mdio_oe_i,
  input logic        busy_i,
  input logic [31:0] cmd_i,
  input logic [31:0] stat_i
);
  AST_MDIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_i |-> $stable(mdio_i) && $stable(mdio_oe_i)); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i[31] |-> !mdio_oe_i && !mdc_i); // R9

  AST_GO_CLEAR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_i[31]) |-> $fell(busy_i)); // R2

  AST_CMD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i[31] && $past(cmd_i[31]) |-> $stable(cmd_i)); // R8

  AST_STATUS_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stat_i) |-> $fell(cmd_i[31]) && !$past(cmd_i[26])); // R10
endmodule

bind mdio_master mdio_master_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mdc_i     (mdc_o),
  .mdio_i    (mdio_o),
  .mdio_oe_i (mdio_oe_o),
  .busy_i    (busy),
  .cmd_i     (cmd_q),
  .stat_i    (stat_q)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 2;
  localparam int FR = 128 * D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       mdc, mdio_o, mdio_oe;
  logic       mdio_i = 1'b1;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.DIV_HALF(D)) i_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // PHY model
  bit          phy_present = 1;
  logic [15:0] phy_val = 16'h0;
  int          rise_cnt = 0;
  logic [63:0] rx = '0;

  always @(posedge mdc) begin
    if (mdio_oe) rx = {rx[62:0], mdio_o};
    rise_cnt++;
  end

  always @(negedge mdc) begin
    if (!phy_present) mdio_i = 1'b1;
    else if (rise_cnt == 47) mdio_i = 1'b0;
    else if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i = phy_val[63 - rise_cnt];
    else mdio_i = 1'b1;
  end

  // cycle reference model
  logic [31:0] m_cmd, m_stat;
  logic [63:0] m_frame;
  logic [15:0] m_rd;
  bit          m_busy, m_wr, m_ta;
  int          m_k;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = '0; m_stat = '0; m_frame = '0; m_rd = '0;
      m_busy = 0; m_wr = 0; m_ta = 0; m_k = 0;
    end else begin
      bit old_go;
      old_go = m_cmd[31];
      if (we && !addr[2] && !old_go) m_cmd[addr[1:0]*8 +: 8] = wdata;
      if (m_busy) begin
        if ((m_k % (2*D)) == D-1 && !m_wr) begin
          int b;
          b = m_k / (2*D);
          if (b == 47) m_ta = mdio_i;
          else if (b >= 48) m_rd = {m_rd[14:0], mdio_i};
        end
        if (m_k == FR-1) begin
          m_busy = 0;
          m_cmd[31] = 1'b0;
          if (!m_wr) m_stat = {m_ta, 15'd0, m_rd};
        end else m_k++;
      end else if (old_go) begin
        m_busy = 1; m_k = 0; m_ta = 0; m_wr = m_cmd[26];
        m_frame = {32'hFFFF_FFFF, 2'b01, (m_wr ? 2'b01 : 2'b10), m_cmd[25:21],
                   m_cmd[20:16], (m_wr ? 2'b10 : 2'b00), (m_wr ? m_cmd[15:0] : 16'h0)};
      end
    end
  end

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !finished) begin
      int  b;
      bit  e_mdc, e_oe, e_mdio;
      logic [31:0] w;
      b      = m_k / (2*D);
      e_mdc  = m_busy && (((m_k / D) % 2) == 1);
      e_oe   = m_busy && (m_wr || b < 46);
      e_mdio = e_oe ? m_frame[63 - b] : 1'b0;
      w      = addr[2] ? m_stat : m_cmd;
      check("R5 mdc phase", 64'(mdc), 64'(e_mdc));
      check("R6 output enable", 64'(mdio_oe), 64'(e_oe));
      check("R4 mdio bit", 64'(mdio_o), 64'(e_mdio));
      check("R1 byte read-back", 64'(rdata), 64'(w[addr[1:0]*8 +: 8]));
    end
  end

  task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_byte(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd_word(input bit st, output logic [31:0] w);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      rd_byte({st, 2'(i)}, b);
      w[i*8 +: 8] = b;
    end
  endtask

  task automatic launch(input logic [31:0] c);
    wr_byte(3'd0, c[7:0]);
    wr_byte(3'd1, c[15:8]);
    wr_byte(3'd2, c[23:16]);
    rise_cnt = 0; rx = '0;
    wr_byte(3'd3, c[31:24]);
  endtask

  task automatic wait_done();
    logic [7:0] b;
    do rd_byte(3'd3, b); while (b[7]);
  endtask

  function automatic logic [63:0] exp_frame(input logic [31:0] c);
    bit w;
    w = c[26];
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), c[25:21], c[20:16],
            (w ? 2'b10 : 2'b00), (w ? c[15:0] : 16'h0)};
  endfunction

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [31:0] c;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 mdc idle", 64'(mdc), 64'd0);
    check("R9 oe released", 64'(mdio_oe), 64'd0);
    rst_n = 1'b1;
    rd_word(0, w); check("R9 command zero", 64'(w), 64'd0);
    rd_word(1, w); check("R9 status zero", 64'(w), 64'd0);

    // R1 byte lanes, go not set
    wr_byte(3'd0, 8'h11); wr_byte(3'd1, 8'h22); wr_byte(3'd2, 8'h33); wr_byte(3'd3, 8'h2A);
    rd_word(0, w); check("R1 lanes", 64'(w), 64'h2A332211);
    wr_byte(3'd5, 8'hFF);
    rd_word(1, w); check("R10 status write ignored", 64'(w), 64'd0);

    // R3 R4 write frame
    c = 32'h8400_0000 | (32'h0A << 21) | (32'h03 << 16) | 32'hBEEF;
    launch(c);
    wait_done();
    check("R4 write frame on line", rx, exp_frame(c));
    check("R5 rising edges per frame", 64'(rise_cnt), 64'd64);
    rd_byte(3'd3, b); check("R2 go cleared", 64'(b[7]), 64'd0);
    rd_word(1, w); check("R10 write keeps status", 64'(w), 64'd0);

    // R6 R7 good read, R8 ignored writes while busy
    phy_present = 1; phy_val = 16'h1234;
    c = 32'h8000_0000 | (32'h1F << 21) | (32'h01 << 16);
    launch(c);
    wr_byte(3'd0, 8'h55);
    wr_byte(3'd2, 8'hAA);
    rd_word(0, w); check("R8 command frozen", 64'(w[30:0]), 64'(c[30:0]));
    wait_done();
    check("R3 read header on line", 64'(rx[45:0]), 64'(exp_frame(c) >> 18));
    rd_word(1, w); check("R7 read status", 64'(w), 64'h0000_1234);

    // R7 failed read
    phy_present = 0;
    c = 32'h8000_0000 | (32'h02 << 21) | (32'h05 << 16);
    launch(c);
    wait_done();
    rd_word(1, w); check("R7 failed read", 64'(w), 64'h8000_FFFF);

    // R6 good read after failure clears flag
    phy_present = 1; phy_val = 16'h8001;
    c = 32'h8000_0000 | (32'h00 << 21) | (32'h1E << 16);
    launch(c);
    wait_done();
    rd_word(1, w); check("R6 read data MSB first", 64'(w), 64'h0000_8001);

    // R10 write after read keeps status
    c = 32'h8400_0000 | (32'h15 << 21) | (32'h0C << 16) | 32'h0F0F;
    launch(c);
    wait_done();
    check("R4 second write frame", rx, exp_frame(c));
    rd_word(1, w); check("R10 status after write", 64'(w), 64'h0000_8001);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule